// File: doc/BRIEF.md
# Bundle-Signalled Redundant NAND Unit

This block computes a two-input NAND in a way that tolerates faults. Each logical operand is carried on a bundle of N parallel wires instead of a single wire. An executive stage of N replicated NAND gates works on matching wire pairs of the two operand bundles. Two cascaded layers of replicated NAND gates then restore the result bundle. Each restoring layer combines the bundle with a rotated copy of itself. The layers act as a nonlinear amplifier that pushes a partly corrupted bundle back toward all-high or all-low, and the two inversions cancel.

The restored bundle goes to a population counter and a two-sided threshold decoder. The decoder reads the bundle as a logical 1 when nearly all wires are high and as a logical 0 when nearly all are low. Between those bands it raises an undecided flag and keeps the previous logical value. An N-bit fault mask flips chosen wires right after the executive stage, so a bench can inject transient wire errors. The output bundle, its count and the decision are all registered.

Top module: `nand_bundle_unit`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising clock edge) clears `bundle_out`, `hi_count`, `dec_bit` and `dec_undec` to zero.
- R2: Executive wire i equals NAND(`a_bus[i]`, `b_bus[i]`) XOR `flt_mask[i]`, for every i from 0 to N-1.
- R3: The restorer has two layers. Wire i of each layer is NAND of wire i and wire (i+ROT) mod N of that layer's input. The second layer's output is the bundle that gets counted.
- R4: All outputs are registered. `bundle_out` shows the restored bundle and `hi_count` shows its number of high wires, both one clock after the inputs are applied.
- R5: When the high-wire count is greater than N-T, the unit clears `dec_undec` and sets `dec_bit` to 1.
- R6: When the high-wire count is less than T, the unit clears `dec_undec` and sets `dec_bit` to 0.
- R7: When the count lies in the closed range T to N-T (including exactly T and exactly N-T), `dec_undec` is 1 and `dec_bit` keeps its previous value.
- R8: With a zero fault mask and uniform operand bundles (each all-ones for logical 1 or all-zeros for logical 0), the unit is decided and `dec_bit` equals NAND of the two logical operands.
- R9: With uniform operands and at most T-1 flipped wires, no two of them 2·ROT positions apart (mod N), the unit is decided and `dec_bit` still equals the fault-free NAND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| a_bus | input | N | First operand bundle |
| b_bus | input | N | Second operand bundle |
| flt_mask | input | N | Wires to invert after the executive stage |
| bundle_out | output | N | Registered restored bundle |
| hi_count | output | $clog2(N+1) | Registered count of high wires in the restored bundle |
| dec_bit | output | 1 | Registered logical value of the bundle (held while undecided) |
| dec_undec | output | 1 | Registered flag: count inside the undecided band |

## Verification
The assertions assume that T is at least 1 and that 2·T is less than N, so the two decided bands never overlap. The NAND-correctness property applies only to cycles where the operand bundles are uniform, the mask is zero and the previous cycle was out of reset. The stimulus drives only uniform operands in those clean vectors. Faulty and mixed vectors use non-zero masks or non-uniform operands, so the property does not apply to them. For fault patterns, the bench keeps flipped wires below T and avoids spacings of 2·ROT wherever it expects the decision to stay correct.

// File: rtl/nbu_pkg.sv
// Package: shared types and index helpers for the bundle NAND unit.
// Assumes the bundle width and rotation are positive.
package nbu_pkg;

    // Three-way outcome of the threshold decoder.
    typedef enum logic [1:0] {
        VD_LOW  = 2'd0,
        VD_HIGH = 2'd1,
        VD_OPEN = 2'd2
    } verdict_e;

    // Partner wire index for a rotation permutation.
    function automatic int unsigned rot_idx(input int unsigned i,
                                            input int unsigned r,
                                            input int unsigned n);
        return (i + r) % n;
    endfunction

endpackage

// File: rtl/nbu_exec.sv
// Module: executive stage. N replicated NAND gates on matching wire
// pairs. Each result wire is then XORed with the fault mask.
// Assumes: all buses are N wires wide.
module nbu_exec #(
    parameter int N = 16
) (
    input  logic [N-1:0] a_w,
    input  logic [N-1:0] b_w,
    input  logic [N-1:0] inj_w,
    output logic [N-1:0] y_w
);
    for (genvar i = 0; i < N; i++) begin : g_gate
        // One replicated gate per wire, with optional fault flip.
        assign y_w[i] = ~(a_w[i] & b_w[i]) ^ inj_w[i];
    end
endmodule

// File: rtl/nbu_restore.sv
// Module: one restoring layer. Wire i is NAND of input wire i and
// input wire (i+ROT) mod N.
// Assumes: 0 < ROT < N, so the partner is a different wire.
module nbu_restore #(
    parameter int N   = 16,
    parameter int ROT = 5
) (
    input  logic [N-1:0] x_w,
    output logic [N-1:0] y_w
);
    for (genvar i = 0; i < N; i++) begin : g_gate
        localparam int J = int'(nbu_pkg::rot_idx(i, ROT, N));
        // Pairwise NAND with the rotated partner wire.
        assign y_w[i] = ~(x_w[i] & x_w[J]);
    end
endmodule

// File: rtl/nbu_popcount.sv
// Module: combinational population count of an N-wire bundle.
// Assumes: CW is wide enough to hold the value N.
module nbu_popcount #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  x_w,
    output logic [CW-1:0] cnt
);
    // Sum the high wires.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(x_w[i]);
        end
    end
endmodule

// File: rtl/nbu_judge.sv
// Module: two-sided threshold classifier. Counts above N-T read high,
// counts below T read low, and everything else is open.
// Assumes: 1 <= T and 2*T < N.
module nbu_judge #(
    parameter int N  = 16,
    parameter int T  = 3,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [CW-1:0]     cnt,
    output nbu_pkg::verdict_e verdict
);
    localparam logic [CW-1:0] HI_EDGE = CW'(N - T);
    localparam logic [CW-1:0] LO_EDGE = CW'(T);

    // Map the count onto one of the three bands.
    always_comb begin
        if (cnt > HI_EDGE)      verdict = nbu_pkg::VD_HIGH;
        else if (cnt < LO_EDGE) verdict = nbu_pkg::VD_LOW;
        else                    verdict = nbu_pkg::VD_OPEN;
    end
endmodule

// File: rtl/nand_bundle_unit.sv
// Module: top of the bundle NAND unit. The chain is executive stage,
// fault injection, two restoring layers, count and threshold decision.
// All outputs are registered with a synchronous active-low reset.
// Assumes: 1 <= T, 2*T < N, 0 < ROT < N.
module nand_bundle_unit #(
    parameter int N   = 16,
    parameter int T   = 3,
    parameter int ROT = 5,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  a_bus,
    input  logic [N-1:0]  b_bus,
    input  logic [N-1:0]  flt_mask,
    output logic [N-1:0]  bundle_out,
    output logic [CW-1:0] hi_count,
    output logic          dec_bit,
    output logic          dec_undec
);
    localparam int LAYERS = 2;

    if (T < 1 || 2 * T >= N) begin : g_bad_thr
        $error("threshold T must satisfy 1 <= T and 2*T < N");
    end
    if (ROT < 1 || ROT >= N) begin : g_bad_rot
        $error("rotation ROT must satisfy 0 < ROT < N");
    end

    logic [N-1:0]      exec_w;
    logic [N-1:0]      stage_w [LAYERS+1];
    logic [CW-1:0]     cnt_w;
    nbu_pkg::verdict_e verdict_w;

    nbu_exec #(.N(N)) u_exec (
        .a_w   (a_bus),
        .b_w   (b_bus),
        .inj_w (flt_mask),
        .y_w   (exec_w)
    );

    assign stage_w[0] = exec_w;

    for (genvar k = 0; k < LAYERS; k++) begin : g_layer
        nbu_restore #(.N(N), .ROT(ROT)) u_rest (
            .x_w (stage_w[k]),
            .y_w (stage_w[k+1])
        );
    end

    nbu_popcount #(.N(N), .CW(CW)) u_cnt (
        .x_w (stage_w[LAYERS]),
        .cnt (cnt_w)
    );

    nbu_judge #(.N(N), .T(T), .CW(CW)) u_judge (
        .cnt     (cnt_w),
        .verdict (verdict_w)
    );

    // Register the bundle, its count and the decision; hold bit when open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bundle_out <= '0;
            hi_count   <= '0;
            dec_bit    <= 1'b0;
            dec_undec  <= 1'b0;
        end else begin
            bundle_out <= stage_w[LAYERS];
            hi_count   <= cnt_w;
            case (verdict_w)
                nbu_pkg::VD_HIGH: begin
                    dec_bit   <= 1'b1;
                    dec_undec <= 1'b0;
                end
                nbu_pkg::VD_LOW: begin
                    dec_bit   <= 1'b0;
                    dec_undec <= 1'b0;
                end
                default: begin
                    dec_undec <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/nbu_chk.sv
// Module: property checker for nand_bundle_unit, attached by bind.
// Assumes: the same N and T as the checked instance.
module nbu_chk #(
    parameter int N  = 16,
    parameter int T  = 3,
    parameter int CW = $clog2(N + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  a_bus,
    input logic [N-1:0]  b_bus,
    input logic [N-1:0]  flt_mask,
    input logic [N-1:0]  bundle_out,
    input logic [CW-1:0] hi_count,
    input logic          dec_bit,
    input logic          dec_undec
);
    // R4
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_count == CW'($countones(bundle_out)));

    // R5
    high_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_undec && dec_bit) |-> (hi_count > CW'(N - T)));

    // R6
    low_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_undec && !dec_bit) |-> (hi_count < CW'(T)));

    // R7
    open_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_undec |-> (hi_count >= CW'(T) && hi_count <= CW'(N - T)));

    // R7
    open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_undec && $past(rst_n)) |-> $stable(dec_bit));

    // R8
    clean_nand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flt_mask) == '0
         && ($past(a_bus) == '0 || $past(a_bus) == '1)
         && ($past(b_bus) == '0 || $past(b_bus) == '1))
        |-> (!dec_undec && dec_bit == !($past(a_bus[0]) && $past(b_bus[0]))));
endmodule

bind nand_bundle_unit nbu_chk #(.N(N), .T(T)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_bus      (a_bus),
    .b_bus      (b_bus),
    .flt_mask   (flt_mask),
    .bundle_out (bundle_out),
    .hi_count   (hi_count),
    .dec_bit    (dec_bit),
    .dec_undec  (dec_undec)
);

// File: tb/sim_nand_bundle_unit.sv
module sim_nand_bundle_unit;
    localparam int N   = 16;
    localparam int T   = 3;
    localparam int ROT = 5;
    localparam int CW  = $clog2(N + 1);
    localparam int NV  = 11;

    // Vector fields: {nand_checked, nand_expected, a, b, mask}
    localparam logic [3*N+1:0] VEC [NV] = '{
        {1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0000}, // clean 1,1 -> 0, count 0
        {1'b1, 1'b1, 16'h0000, 16'hFFFF, 16'h0000}, // clean 0,1 -> 1
        {1'b1, 1'b1, 16'hFFFF, 16'h0000, 16'h0000}, // clean 1,0 -> 1
        {1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0000}, // clean 0,0 -> 1
        {1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0021}, // R9 two faults, count 2 -> 0
        {1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0204}, // R9 two faults, count 14 -> 1
        {1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0421}, // count exactly T -> open
        {1'b1, 1'b1, 16'h0000, 16'hFFFF, 16'h0004}, // R9 one fault -> 1
        {1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0401}, // count exactly N-T -> open
        {1'b0, 1'b0, 16'h00FF, 16'hFFFF, 16'h0000}, // mixed operand bundle
        {1'b0, 1'b0, 16'hF0F0, 16'h3C3C, 16'h8001}  // mixed with faults
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  a_bus = '0;
    logic [N-1:0]  b_bus = '0;
    logic [N-1:0]  flt_mask = '0;
    logic [N-1:0]  bundle_out;
    logic [CW-1:0] hi_count;
    logic          dec_bit;
    logic          dec_undec;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_bit = 1'b0;

    always #2 clk = ~clk;

    nand_bundle_unit #(.N(N), .T(T), .ROT(ROT)) u0 (
        .clk(clk), .rst_n(rst_n), .a_bus(a_bus), .b_bus(b_bus),
        .flt_mask(flt_mask), .bundle_out(bundle_out), .hi_count(hi_count),
        .dec_bit(dec_bit), .dec_undec(dec_undec)
    );

    // Reference bundle built from R2 and R3.
    function automatic logic [N-1:0] ref_bundle(input logic [N-1:0] a,
                                                 input logic [N-1:0] b,
                                                 input logic [N-1:0] m);
        logic [N-1:0] e, r1, r2;
        e = ~(a & b) ^ m;
        for (int i = 0; i < N; i++) r1[i] = ~(e[i] & e[(i + ROT) % N]);
        for (int i = 0; i < N; i++) r2[i] = ~(r1[i] & r1[(i + ROT) % N]);
        return r2;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b,
                         input logic [N-1:0] m);
        @(negedge clk);
        a_bus = a; b_bus = b; flt_mask = m;
        @(posedge clk);
        #1;
    endtask

    // Check outputs for the applied inputs against R2-R7.
    task automatic expect_outputs(input logic [N-1:0] a, input logic [N-1:0] b,
                                  input logic [N-1:0] m);
        logic [N-1:0] rb;
        int c;
        logic undec;
        rb = ref_bundle(a, b, m);
        c = $countones(rb);
        check("R2 R3 bundle", bundle_out, rb);
        check("R4 count", hi_count, c);
        if (c > N - T) begin
            undec = 1'b0; exp_bit = 1'b1;
            check("R5 high band bit", dec_bit, 1);
        end else if (c < T) begin
            undec = 1'b0; exp_bit = 1'b0;
            check("R6 low band bit", dec_bit, 0);
        end else begin
            undec = 1'b1;
            check("R7 held bit", dec_bit, exp_bit);
        end
        check("R5 R6 R7 undecided flag", dec_undec, undec);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 bundle after reset", bundle_out, 0);
        check("R1 count after reset", hi_count, 0);
        check("R1 bit after reset", dec_bit, 0);
        check("R1 undecided after reset", dec_undec, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][3*N-1:2*N], VEC[v][2*N-1:N], VEC[v][N-1:0]);
            expect_outputs(VEC[v][3*N-1:2*N], VEC[v][2*N-1:N], VEC[v][N-1:0]);
            if (VEC[v][3*N+1]) begin
                // R8 and R9 decided value equals logical NAND
                check("R8 R9 decided", dec_undec, 0);
                check("R8 R9 nand value", dec_bit, VEC[v][3*N]);
            end
        end

        // R7 exactly T high wires while holding 0
        apply(16'hFFFF, 16'hFFFF, 16'h0000);
        expect_outputs(16'hFFFF, 16'hFFFF, 16'h0000);
        apply(16'hFFFF, 16'hFFFF, 16'h0421);
        check("R7 count at T", hi_count, T);
        check("R7 open at T", dec_undec, 1);
        check("R7 hold 0", dec_bit, 0);

        // R7 exactly N-T high wires while holding 1
        apply(16'h0000, 16'hFFFF, 16'h0000);
        apply(16'h0000, 16'h0000, 16'h0401);
        check("R7 count at N-T", hi_count, N - T);
        check("R7 open at N-T", dec_undec, 1);
        check("R7 hold 1", dec_bit, 1);

        // R4 one-cycle latency: output stays until the next edge
        @(negedge clk);
        a_bus = 16'hFFFF; b_bus = 16'hFFFF; flt_mask = '0;
        #1;
        check("R4 no early change", hi_count, N - T);
        @(posedge clk);
        #1;
        check("R4 updated", hi_count, 0);

        // R1 reset mid-run after decided 1
        apply(16'h0000, 16'hFFFF, 16'h0000);
        check("R5 before reset", dec_bit, 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid bundle", bundle_out, 0);
        check("R1 mid count", hi_count, 0);
        check("R1 mid bit", dec_bit, 0);
        check("R1 mid undecided", dec_undec, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule